// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a two-part logical address (a segment number plus an offset inside that segment) into a physical address. It uses a segment table that lives in memory. One descriptor per memory word sits at table base + segment number. Two plain control inputs set where the table starts and how many segments it holds. Both are sampled when a request is taken. The block first rejects a segment number that is not below the table length, and then issues no memory read. Otherwise it reads the descriptor through a memory read port and checks it. Last, it returns either the relocated address or a fault code.

A descriptor word holds these fields, from the least significant bit up: the segment base (PA_W bits), the segment limit (OFF_W+1 bits, so a full-size segment can be described), a valid bit, then read, write and execute permission bits. The checks run in a fixed order, and the first one that fails sets the reported code. The order is segment number against table length, then the valid bit, then offset against limit, then permission for the requested access.

All three data interfaces use valid/ready handshakes. A transfer happens on a rising edge where both signals are high. The block takes one request at a time. It holds a descriptor read, and a result, with stable content until the other side accepts it. Back-pressure on the result port therefore stalls the request port.

Top module: `seg_xlate_unit`

## Requirements
- R1: `req_ready_o` is high only when no translation is in flight. After a request is taken, it stays low until the result has been accepted.
- R2: If the segment number is not strictly below `table_len_i`, no descriptor read is issued. The result appears one cycle after acceptance, with fault code 1 (length).
- R3: For a legal segment, one descriptor read is issued at address `table_base_i + segment` (modulo 2^PA_W). Its valid and address hold steady until `mem_rd_ready_i` is high.
- R4: A descriptor whose valid bit (bit PA_W+OFF_W+1) is 0 gives fault code 2 (invalid). This code wins over the limit and permission checks.
- R5: On a valid descriptor, an offset greater than or equal to the limit (bits PA_W+OFF_W..PA_W) gives fault code 3 (limit). This code wins over the permission check.
- R6: Access codes are 0 read, 1 write, 2 execute and 3 reserved. A read needs bit PA_W+OFF_W+2, a write needs bit PA_W+OFF_W+3, and an execute needs bit PA_W+OFF_W+4. A missing permission, or the reserved code, gives fault code 4 (permission).
- R7: When every check passes, the fault code is 0 and the physical address is the base (bits PA_W-1..0) plus the zero-extended offset, modulo 2^PA_W.
- R8: Any faulted result carries a physical address of 0.
- R9: A result appears two cycles after the descriptor word is delivered. It stays valid with stable content until `rsp_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| table_base_i | input | PA_W | Memory word address of segment 0's descriptor |
| table_len_i | input | SEG_W+1 | Number of segments in the table |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_seg_i | input | SEG_W | Segment number |
| req_off_i | input | OFF_W | Offset inside the segment |
| req_acc_i | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| mem_rd_valid_o | output | 1 | Descriptor read request valid |
| mem_rd_ready_i | input | 1 | Memory accepts the read request |
| mem_rd_addr_o | output | PA_W | Descriptor word address |
| mem_rsp_valid_i | input | 1 | Descriptor word delivered |
| mem_rsp_data_i | input | PA_W+OFF_W+5 | Descriptor word |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result accepted |
| rsp_paddr_o | output | PA_W | Physical address (0 on fault) |
| rsp_fault_o | output | 3 | Fault code: 0 none, 1 length, 2 invalid, 3 limit, 4 permission |

## Verification
A result is due at one of two points. A length fault shows one cycle after the accepting edge. Every other outcome shows two cycles after the edge that delivers the descriptor word, because that word passes through a capture stage and a check stage. The bench drives every input on the falling edge and compares the outputs on each falling edge in between. Each comparison uses the cycle count worked out above. Stalls on the read request and on the result port stretch the wait by a known number of cycles, so the expected hold of every output is also checked cycle by cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_LENGTH  = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_PERM    = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_FETCH_REQ  = 3'd1,
    ST_FETCH_WAIT = 3'd2,
    ST_CHECK      = 3'd3,
    ST_RESPOND    = 3'd4
  } xl_state_e;

endpackage

// File: rtl/seg_entry_check.sv
module seg_entry_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PA_W  = 20,
  localparam int LIM_W  = OFF_W + 1,
  localparam int LIM_LO = PA_W,
  localparam int VLD_B  = PA_W + LIM_W,
  localparam int PRM_LO = VLD_B + 1,
  localparam int DESC_W = PRM_LO + 3
) (
  input  logic [DESC_W-1:0] desc_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        acc_i,
  output fault_e            fault_o,
  output logic [PA_W-1:0]   paddr_o
);

  logic [PA_W-1:0]  seg_base;
  logic [LIM_W-1:0] seg_limit;
  logic             seg_valid;
  logic [2:0]       perm_rwx;
  logic             in_range;
  logic             granted;

  assign seg_base  = desc_i[PA_W-1:0];
  assign seg_limit = desc_i[LIM_LO +: LIM_W];
  assign seg_valid = desc_i[VLD_B];
  assign perm_rwx  = desc_i[PRM_LO +: 3];

  assign in_range = {1'b0, off_i} < seg_limit;

  always_comb begin
    case (acc_i)
      ACC_READ:  granted = perm_rwx[0];
      ACC_WRITE: granted = perm_rwx[1];
      ACC_EXEC:  granted = perm_rwx[2];
      default:   granted = 1'b0;
    endcase
  end

  always_comb begin
    if (!seg_valid)     fault_o = FLT_INVALID;
    else if (!in_range) fault_o = FLT_LIMIT;
    else if (!granted)  fault_o = FLT_PERM;
    else                fault_o = FLT_NONE;
  end

  assign paddr_o = seg_base + PA_W'(off_i);

endmodule

// File: rtl/seg_ctrl_fsm.sv
module seg_ctrl_fsm
  import seg_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_fire_i,
  input  logic      len_ok_i,
  input  logic      rd_fire_i,
  input  logic      word_in_i,
  input  logic      rsp_fire_i,
  output xl_state_e state_o
);

  xl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (req_fire_i) state_d = len_ok_i ? ST_FETCH_REQ : ST_RESPOND;
      ST_FETCH_REQ:  if (rd_fire_i)  state_d = ST_FETCH_WAIT;
      ST_FETCH_WAIT: if (word_in_i)  state_d = ST_CHECK;
      ST_CHECK:      state_d = ST_RESPOND;
      ST_RESPOND:    if (rsp_fire_i) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  length_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && req_fire_i && !len_ok_i) |=> state_q == ST_RESPOND);

  // R9
  check_to_respond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH_WAIT && word_in_i) |=> ##1 state_q == ST_RESPOND);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 20,
  localparam int DESC_W = PA_W + OFF_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   table_base_i,
  input  logic [SEG_W:0]    table_len_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [1:0]        req_acc_i,
  output logic              mem_rd_valid_o,
  input  logic              mem_rd_ready_i,
  output logic [PA_W-1:0]   mem_rd_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DESC_W-1:0] mem_rsp_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic [2:0]        rsp_fault_o
);

  xl_state_e         state;
  logic              req_fire, rd_fire, word_in, rsp_fire, len_ok;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        acc_q;
  logic [PA_W-1:0]   rd_addr_q;
  logic [DESC_W-1:0] desc_q;
  fault_e            fault_q, chk_fault;
  logic [PA_W-1:0]   paddr_q, chk_paddr;

  assign req_ready_o    = (state == ST_IDLE);
  assign mem_rd_valid_o = (state == ST_FETCH_REQ);
  assign rsp_valid_o    = (state == ST_RESPOND);

  assign req_fire = req_valid_i && req_ready_o;
  assign rd_fire  = mem_rd_valid_o && mem_rd_ready_i;
  assign word_in  = (state == ST_FETCH_WAIT) && mem_rsp_valid_i;
  assign rsp_fire = rsp_valid_o && rsp_ready_i;
  assign len_ok   = {1'b0, req_seg_i} < table_len_i;

  seg_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire_i (req_fire),
    .len_ok_i   (len_ok),
    .rd_fire_i  (rd_fire),
    .word_in_i  (word_in),
    .rsp_fire_i (rsp_fire),
    .state_o    (state)
  );

  seg_entry_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .desc_i  (desc_q),
    .off_i   (off_q),
    .acc_i   (acc_q),
    .fault_o (chk_fault),
    .paddr_o (chk_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q     <= '0;
      acc_q     <= '0;
      rd_addr_q <= '0;
      desc_q    <= '0;
      fault_q   <= FLT_NONE;
      paddr_q   <= '0;
    end else begin
      if (req_fire) begin
        off_q     <= req_off_i;
        acc_q     <= req_acc_i;
        rd_addr_q <= table_base_i + PA_W'(req_seg_i);
        paddr_q   <= '0;
        fault_q   <= len_ok ? FLT_NONE : FLT_LENGTH;
      end
      if (word_in) desc_q <= mem_rsp_data_i;
      if (state == ST_CHECK) begin
        fault_q <= chk_fault;
        paddr_q <= (chk_fault == FLT_NONE) ? chk_paddr : '0;
      end
    end
  end

  assign mem_rd_addr_o = rd_addr_q;
  assign rsp_paddr_o   = paddr_q;
  assign rsp_fault_o   = fault_q;

  // R1
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready_o);

  // R2
  no_read_on_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !len_ok) |=> (!mem_rd_valid_o && rsp_valid_o && rsp_fault_o == FLT_LENGTH));

  // R3
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid_o && !mem_rd_ready_i) |=> (mem_rd_valid_o && $stable(mem_rd_addr_o)));

  // R8
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_fault_o != FLT_NONE) |-> rsp_paddr_o == '0);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o)));

endmodule

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;

  localparam int SEG_W = 4;
  localparam int OFF_W = 12;
  localparam int PA_W  = 20;
  localparam int DW    = PA_W + OFF_W + 5;
  localparam int NSEG  = 1 << SEG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [PA_W-1:0]  table_base = '0;
  logic [SEG_W:0]   table_len  = '0;
  logic             req_valid = 1'b0, req_ready;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0]       req_acc = '0;
  logic             mem_rd_valid, mem_rd_ready = 1'b0;
  logic [PA_W-1:0]  mem_rd_addr;
  logic             mem_rsp_valid = 1'b0;
  logic [DW-1:0]    mem_rsp_data = '0;
  logic             rsp_valid, rsp_ready = 1'b0;
  logic [PA_W-1:0]  rsp_paddr;
  logic [2:0]       rsp_fault;

  seg_xlate_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_seg_xlate_unit (
    .clk(clk), .rst_n(rst_n),
    .table_base_i(table_base), .table_len_i(table_len),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_seg_i(req_seg), .req_off_i(req_off), .req_acc_i(req_acc),
    .mem_rd_valid_o(mem_rd_valid), .mem_rd_ready_i(mem_rd_ready), .mem_rd_addr_o(mem_rd_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  int unsigned d_base [NSEG];
  int unsigned d_lim  [NSEG];
  bit d_v[NSEG], d_r[NSEG], d_w[NSEG], d_x[NSEG];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int s);
    logic [DW-1:0] w;
    w = {d_x[s], d_w[s], d_r[s], d_v[s], 13'(d_lim[s]), 20'(d_base[s])};
    return w;
  endfunction

  task automatic expect_of(input int s, input int off, input int acc,
                           output int f, output int pa);
    bit ok_perm;
    pa = 0;
    ok_perm = (acc == 0) ? d_r[s] : (acc == 1) ? d_w[s] : (acc == 2) ? d_x[s] : 1'b0;
    if (s >= int'(table_len))         f = 1;
    else if (!d_v[s])                 f = 2;
    else if (off >= int'(d_lim[s]))   f = 3;
    else if (!ok_perm)                f = 4;
    else begin
      f = 0;
      pa = (d_base[s] + off) % (1 << PA_W);
    end
  endtask

  task automatic xact(input int s, input int off, input int acc,
                      input int rd_stall, input int mem_dly, input int out_stall, input string tag);
    int ef, ep;
    int ea;
    expect_of(s, off, acc, ef, ep);
    ea = (int'(table_base) + s) % (1 << PA_W);
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, {"R1 idle before ", tag}, req_ready, 1);
    req_valid = 1'b1; req_seg = SEG_W'(s); req_off = OFF_W'(off); req_acc = 2'(acc);
    @(negedge clk);
    req_valid = 1'b0;
    if (ef == 1) begin
      chk(mem_rd_valid == 1'b0, {"R2 no read ", tag}, mem_rd_valid, 0);
    end else begin
      chk(req_ready == 1'b0, {"R1 busy ", tag}, req_ready, 0);
      chk(rsp_valid == 1'b0, {"R9 early ", tag}, rsp_valid, 0);
      chk(mem_rd_valid == 1'b1 && int'(mem_rd_addr) == ea, {"R3 read addr ", tag}, mem_rd_addr, ea);
      for (int i = 0; i < rd_stall; i++) begin
        @(negedge clk);
        chk(mem_rd_valid == 1'b1 && int'(mem_rd_addr) == ea, {"R3 hold ", tag}, mem_rd_addr, ea);
      end
      mem_rd_ready = 1'b1;
      @(negedge clk);
      mem_rd_ready = 1'b0;
      chk(mem_rd_valid == 1'b0, {"R3 single read ", tag}, mem_rd_valid, 0);
      for (int i = 0; i < mem_dly; i++) begin
        @(negedge clk);
        chk(rsp_valid == 1'b0 && mem_rd_valid == 1'b0, {"R9 wait ", tag}, rsp_valid, 0);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = word_of(s);
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      chk(rsp_valid == 1'b0, {"R9 check stage ", tag}, rsp_valid, 0);
      @(negedge clk);
    end
    chk(rsp_valid == 1'b1, {"R9 due ", tag}, rsp_valid, 1);
    chk(int'(rsp_fault) == ef, {"R2/R4/R5/R6/R7 fault ", tag}, rsp_fault, ef);
    chk(int'(rsp_paddr) == ep, {"R7/R8 paddr ", tag}, rsp_paddr, ep);
    for (int i = 0; i < out_stall; i++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1 && int'(rsp_fault) == ef && int'(rsp_paddr) == ep,
          {"R9 hold ", tag}, rsp_paddr, ep);
      chk(req_ready == 1'b0, {"R1 stalled ", tag}, req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, {"R1 release ", tag}, req_ready, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < NSEG; i++) begin
      d_base[i] = i << 12; d_lim[i] = 'h800;
      d_v[i] = 1; d_r[i] = 1; d_w[i] = 1; d_x[i] = 1;
    end
    d_base[0] = 'h10000; d_lim[0] = 'h200; d_x[0] = 0;
    d_base[1] = 'h20000; d_lim[1] = 'h080; d_v[1] = 0;
    d_base[2] = 'h30000; d_lim[2] = 'h100; d_w[2] = 0; d_x[2] = 0;
    d_base[3] = 'h40000; d_lim[3] = 'h040; d_r[3] = 0; d_w[3] = 0;
    d_base[4] = 'hFFF00; d_lim[4] = 'h1000;
    d_base[5] = 'h05000; d_lim[5] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(rsp_valid == 1'b0 && mem_rd_valid == 1'b0, "R9 reset quiet", rsp_valid, 0);

    table_base = 20'h00100; table_len = 5'd8;
    xact(0, 'h1FF, 0, 0, 0, 0, "R7 read in range");
    xact(0, 'h200, 1, 2, 1, 1, "R5 off equals limit");
    xact(1, 'h300, 2, 0, 3, 0, "R4 invalid wins");
    xact(2, 'h010, 1, 1, 0, 2, "R6 write denied");
    xact(2, 'h100, 1, 0, 0, 0, "R5 limit over perm");
    xact(3, 'h03F, 2, 3, 2, 0, "R7 exec allowed");
    xact(3, 'h000, 0, 0, 0, 1, "R6 read denied");
    xact(0, 'h001, 3, 0, 1, 0, "R6 reserved access");
    xact(5, 'h000, 0, 0, 0, 0, "R5 zero limit");
    xact(8, 'h000, 0, 0, 0, 0, "R2 seg equals len");
    xact(15, 'h000, 0, 0, 0, 3, "R2 seg above len");
    xact(7, 'h7FF, 1, 1, 1, 0, "R7 last legal seg");

    table_base = 20'hFFFFC; table_len = 5'd16;
    xact(4, 'h1F0, 0, 0, 0, 0, "R7 paddr wraps");
    xact(4, 'hFFF, 1, 2, 0, 1, "R7 full segment");
    xact(15, 'h123, 2, 0, 2, 0, "R3 table addr wraps");

    table_len = 5'd0;
    xact(0, 'h000, 0, 0, 0, 2, "R2 empty table");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule